// File: doc/BRIEF.md
# Scratchpad EEPROM Memory Command Controller

This block is the memory-command layer of a single-wire serial EEPROM slave. It begins work once the device has been selected. A bit-level front end hands it received bytes and asks it for one bit at a time whenever the master opens a read slot. Behind it sit a 32-byte scratchpad, two target-address registers, an ending-offset/status register and a 512-byte array that stands in for the non-volatile storage.

The master never writes the array directly. It first fills the scratchpad with data. It can then read the scratchpad back to check it. Last, it commits the data by echoing the address and status registers as a three-byte authorization. A direct read-memory command streams bytes out of the array and also refreshes the scratchpad with the page being read. A write that runs to the last scratchpad offset may be followed by an inverted CRC-16 over everything the master sent. The programming time is modelled by a cycle counter.

Top module: `sp_eeprom_ctrl`

## Requirements
- R1: After reset the target registers read 00h/00h and the status byte reads 20h, because the scratchpad contents count as lost and the partial flag is set.
- R2: The first byte after a bus reset selects the command: 0Fh write scratchpad, AAh read scratchpad, 55h copy, F0h read memory. Any other value makes every later read slot return 1 until the next bus reset.
- R3: Write scratchpad takes a low then a high address byte. It clears the accepted flag (status bit 7) and the partial flag (status bit 5). It loads the ending offset (status bits 4:0) with address bits 4:0, stores each complete data byte at the next scratchpad offset starting there, and sets the ending offset to the offset of the last complete byte. Status bit 6 always reads 0.
- R4: An incomplete data byte during write scratchpad is discarded and sets the partial flag. The next write scratchpad command clears the flag again.
- R5: Every received address is kept with its upper 7 bits forced to 0, so the high address register holds only bit 0.
- R6: When a write fills scratchpad offset 31, the next 16 read slots return the bitwise inverse of a CRC-16. The CRC uses polynomial x^16+x^15+x^2+1, starts at zero, and is fed LSB first with the command byte, both address bytes as sent and all data bytes. After these 16 slots every read slot returns 1.
- R7: Read scratchpad returns, in this order, the low address, the high address, the status byte, and then the scratchpad bytes from address bits 4:0 through offset 31. Every byte after that reads FFh. All bytes go out LSB first.
- R8: Copy succeeds only when the three bytes that follow it equal the low address, high address and status registers, in that order. On success the accepted flag is set, scratchpad offsets from address bits 4:0 through the ending offset are written to the array page the address selects, and after programming the read slots return alternating bits starting with 0. On any mismatch the read slots return 1 and the array is left unchanged.
- R9: Read memory overwrites the target registers, streams array bytes from the address up to 01FFh, and returns FFh after that. It loads the scratchpad with the page of the address, and with the following page once the last byte of a page has been sent.
- R10: A programming interval lasts PROG_CYCLES clock cycles. During it, read-slot requests get no response and bus reset is ignored. At any other time a bus reset abandons the current command, and the next byte is taken as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Bus reset pulse from the bit-level layer |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_partial | input | 1 | The received byte was incomplete |
| tx_req | input | 1 | The master opened a read slot |
| tx_ready | output | 1 | Answer bit valid, one cycle after tx_req |
| tx_bit | output | 1 | Bit returned for the read slot |
| prog_busy | output | 1 | Programming interval in progress |

## Verification
The bench builds the block with PROG_CYCLES set to 12. This keeps every programming interval short, so several copies fit in one run: one to the first page, one to the last page and one to the second page, plus a rejected copy. The short interval also lets the bench probe the busy window directly, with a read request and a bus reset sent inside it, and then read the alternating-bit answer. Writes start at offset 28 or 30, so the final offset, the CRC and the page-crossing scratchpad reload are all reached within a handful of bytes.

// File: rtl/sp_eeprom_ctrl.sv
module sp_eeprom_ctrl #(
  parameter int PROG_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_partial,
  input  logic       tx_req,
  output logic       tx_ready,
  output logic       tx_bit,
  output logic       prog_busy
);
  localparam int PW = $clog2(PROG_CYCLES + 1);

  typedef enum logic [3:0] {S_CMD, S_A1, S_A2, S_WDAT, S_WCRC, S_RSP,
                            S_AUTH, S_PROG, S_ALT, S_RMEM, S_ONES} st_t;

  st_t         st;
  logic [7:0]  cmd, ta1, ta2;
  logic        aa, pf, okm, alt;
  logic [4:0]  eoff;
  logic [5:0]  ptr;
  logic [1:0]  hcnt;
  logic [9:0]  maddr;
  logic [2:0]  bidx;
  logic [15:0] crc;
  logic [PW-1:0] pcnt;
  logic [7:0]  sp  [32];
  logic [7:0]  mem [512];
  logic [7:0]  es, txb, expb;
  logic [8:0]  mnext;

  function automatic logic [15:0] crc_next(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  assign es        = {aa, 1'b0, pf, eoff};
  assign prog_busy = (st == S_PROG);
  assign mnext     = maddr[8:0] + 9'd1;
  assign expb      = (ptr[1:0] == 2'd0) ? ta1 : (ptr[1:0] == 2'd1) ? ta2 : es;

  always_comb begin
    txb = 8'hFF;
    case (st)
      S_RSP:  txb = (hcnt == 2'd0) ? ta1 : (hcnt == 2'd1) ? ta2 :
                    (hcnt == 2'd2) ? es  : (ptr[5] ? 8'hFF : sp[ptr[4:0]]);
      S_RMEM: txb = maddr[9] ? 8'hFF : mem[maddr[8:0]];
      S_WCRC: txb = (hcnt == 2'd0) ? ~crc[7:0] : (hcnt == 2'd1) ? ~crc[15:8] : 8'hFF;
      default: txb = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_CMD; cmd <= 8'h00; ta1 <= 8'h00; ta2 <= 8'h00;
      aa <= 1'b0; pf <= 1'b1; eoff <= 5'd0; okm <= 1'b0; alt <= 1'b0;
      ptr <= 6'd0; hcnt <= 2'd0; maddr <= 10'd0; bidx <= 3'd0;
      crc <= 16'h0000; pcnt <= '0; tx_ready <= 1'b0; tx_bit <= 1'b1;
    end else begin
      tx_ready <= 1'b0;
      if (st == S_PROG) begin
        pcnt <= pcnt + 1'b1;
        if (pcnt == PW'(PROG_CYCLES - 1)) begin
          st <= S_ALT; alt <= 1'b0;
        end
      end else if (bus_reset) begin
        st <= S_CMD; bidx <= 3'd0;
      end else if (rx_valid) begin
        bidx <= 3'd0;
        if (rx_partial) begin
          if (st == S_WDAT) pf <= 1'b1;
          st <= S_ONES;
        end else begin
          case (st)
            S_CMD: begin
              cmd <= rx_byte;
              crc <= crc_next(16'h0000, rx_byte);
              case (rx_byte)
                8'h0F: begin aa <= 1'b0; pf <= 1'b0; st <= S_A1; end
                8'hF0: st <= S_A1;
                8'hAA: begin st <= S_RSP; hcnt <= 2'd0; ptr <= {1'b0, ta1[4:0]}; end
                8'h55: begin st <= S_AUTH; ptr <= 6'd0; okm <= 1'b1; end
                default: st <= S_ONES;
              endcase
            end
            S_A1: begin
              ta1 <= rx_byte; crc <= crc_next(crc, rx_byte); st <= S_A2;
            end
            S_A2: begin
              ta2 <= {7'd0, rx_byte[0]};
              crc <= crc_next(crc, rx_byte);
              if (cmd == 8'h0F) begin
                eoff <= ta1[4:0]; ptr <= {1'b0, ta1[4:0]}; st <= S_WDAT;
              end else begin
                maddr <= {1'b0, rx_byte[0], ta1};
                for (int i = 0; i < 32; i++)
                  sp[i] <= mem[{rx_byte[0], ta1[7:5], 5'(i)}];
                st <= S_RMEM;
              end
            end
            S_WDAT: begin
              sp[ptr[4:0]] <= rx_byte;
              eoff <= ptr[4:0];
              crc  <= crc_next(crc, rx_byte);
              if (ptr[4:0] == 5'd31) begin
                st <= S_WCRC; hcnt <= 2'd0;
              end else ptr <= ptr + 6'd1;
            end
            S_AUTH: begin
              if (ptr[1:0] == 2'd2) begin
                if (okm && rx_byte == expb) begin
                  aa <= 1'b1;
                  for (int i = 0; i < 32; i++)
                    if (5'(i) >= ta1[4:0] && 5'(i) <= eoff)
                      mem[{ta2[0], ta1[7:5], 5'(i)}] <= sp[i];
                  pcnt <= '0; st <= S_PROG;
                end else st <= S_ONES;
              end else begin
                okm <= okm && (rx_byte == expb);
                ptr <= ptr + 6'd1;
              end
            end
            default: ;
          endcase
        end
      end else if (tx_req) begin
        tx_ready <= 1'b1;
        tx_bit   <= (st == S_ALT) ? alt : txb[bidx];
        if (st == S_ALT) alt <= ~alt;
        bidx <= bidx + 3'd1;
        if (bidx == 3'd7) begin
          case (st)
            S_RSP:  if (hcnt != 2'd3) hcnt <= hcnt + 2'd1;
                    else if (!ptr[5]) ptr <= ptr + 6'd1;
            S_WCRC: if (hcnt != 2'd2) hcnt <= hcnt + 2'd1;
            S_RMEM: if (!maddr[9]) begin
                      maddr <= maddr + 10'd1;
                      if (maddr[4:0] == 5'd31 && maddr[8:0] != 9'd511)
                        for (int i = 0; i < 32; i++)
                          sp[i] <= mem[{mnext[8:5], 5'(i)}];
                    end
            default: ;
          endcase
        end
      end
    end
  end

  a_r3_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && rx_valid && !rx_partial && !bus_reset && rx_byte == 8'h0F) |=> (!aa && !pf));
  a_r4_partial_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDAT && rx_valid && rx_partial && !bus_reset) |=> pf);
  a_r8_accept_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_busy) |-> aa);
  a_r10_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && $past(prog_busy)) |-> !tx_ready);
  a_r2_ones_state: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ONES && tx_req && !rx_valid && !bus_reset) |=> (tx_ready && tx_bit));
  a_r7_tail_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RSP && hcnt == 2'd3 && ptr[5] && tx_req && !rx_valid && !bus_reset) |=> tx_bit);
endmodule

// File: tb/sp_eeprom_ctrl_tb_top.sv
module sp_eeprom_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 12;

  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0, rx_valid = 1'b0, rx_partial = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic tx_ready, tx_bit, prog_busy;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_eeprom_ctrl #(.PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_partial(rx_partial), .tx_req(tx_req),
    .tx_ready(tx_ready), .tx_bit(tx_bit), .prog_busy(prog_busy));

  // {ta1, ta2, nbytes, expected ta2, expected status}
  localparam logic [35:0] VEC [5] = '{
    {8'h1C, 8'h00, 4'd3, 8'h00, 8'h1E},
    {8'h05, 8'hFE, 4'd1, 8'h00, 8'h05},
    {8'h40, 8'h01, 4'd2, 8'h01, 8'h01},
    {8'hE7, 8'h83, 4'd4, 8'h01, 8'h0A},
    {8'h10, 8'h00, 4'd0, 8'h00, 8'h10}};

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic part = 1'b0);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b; rx_partial = part;
    @(negedge clk); rx_valid = 1'b0; rx_partial = 1'b0;
  endtask

  task automatic breset();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic rbit(output logic b, output logic rdy);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0; b = tx_bit; rdy = tx_ready;
  endtask

  task automatic rbyte(output logic [7:0] v);
    logic b, r;
    for (int k = 0; k < 8; k++) begin rbit(b, r); v[k] = b; end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] m [8], input int n);
    logic [15:0] r = 16'h0000, o;
    logic fb;
    for (int j = 0; j < n; j++)
      for (int k = 0; k < 8; k++) begin
        fb = r[15] ^ m[j][k];
        r = {r[14:0], 1'b0};
        if (fb) r = r ^ 16'h8005;
      end
    for (int k = 0; k < 16; k++) o[k] = r[15-k];
    return o;
  endfunction

  task automatic header(input string req, input logic [7:0] e1, input logic [7:0] e2, input logic [7:0] e3);
    logic [7:0] v;
    breset(); send(8'hAA);
    rbyte(v); check({req, " low address"}, {8'h00, v}, {8'h00, e1});
    rbyte(v); check({req, " high address"}, {8'h00, v}, {8'h00, e2});
    rbyte(v); check({req, " status"}, {8'h00, v}, {8'h00, e3});
  endtask

  task automatic waitprog();
    repeat (PROG + 3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] w;
    logic b, r;
    logic [7:0] msg [8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    header("R1 reset", 8'h00, 8'h00, 8'h20);

    // R4: partial byte discarded, flag set
    breset(); send(8'h0F); send(8'h1C); send(8'h00); send(8'h55); send(8'h66, 1'b1);
    header("R4 partial", 8'h1C, 8'h00, 8'h3C);

    // R3/R5 table: status layout, offsets, address masking
    for (int t = 0; t < 5; t++) begin
      breset(); send(8'h0F); send(VEC[t][35:28]); send(VEC[t][27:20]);
      for (int k = 0; k < int'(VEC[t][19:16]); k++) send(8'hA0 + 8'(k));
      header($sformatf("R3 R5 vector %0d", t), VEC[t][35:28], VEC[t][15:8], VEC[t][7:0]);
    end

    // R6: reach offset 31, inverted CRC then ones
    msg = '{8'h0F, 8'h1C, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00};
    breset(); for (int k = 0; k < 7; k++) send(msg[k]);
    for (int k = 0; k < 16; k++) begin rbit(b, r); w[k] = b; end
    check("R6 inverted crc", w, ~ref_crc(msg, 7));
    rbyte(v); check("R6 ones after crc", {8'h00, v}, 16'h00FF);

    // R7: read scratchpad order and tail
    header("R7 readback", 8'h1C, 8'h00, 8'h1F);
    rbyte(v); check("R7 data 0", {8'h00, v}, 16'h0011);
    rbyte(v); check("R7 data 1", {8'h00, v}, 16'h0022);
    rbyte(v); check("R7 data 2", {8'h00, v}, 16'h0033);
    rbyte(v); check("R7 data 3", {8'h00, v}, 16'h0044);
    rbyte(v); check("R7 past end", {8'h00, v}, 16'h00FF);

    // R8/R10: copy, busy window, alternating pattern
    breset(); send(8'h55); send(8'h1C); send(8'h00); send(8'h1F);
    rbit(b, r); check("R10 no answer while busy", {15'd0, r}, 16'h0000);
    breset();
    waitprog();
    rbyte(v); check("R8 alternating after copy", {8'h00, v}, 16'h00AA);
    header("R8 accepted flag", 8'h1C, 8'h00, 8'h9F);

    // R9/R5: last page, masked address, FF past end, scratchpad reload
    breset(); send(8'h0F); send(8'hFE); send(8'h01); send(8'h5A); send(8'hC3);
    breset(); send(8'h55); send(8'hFE); send(8'h01); send(8'h1F); waitprog();
    breset(); send(8'hF0); send(8'hFE); send(8'h03);
    rbyte(v); check("R9 byte 1FE", {8'h00, v}, 16'h005A);
    rbyte(v); check("R9 byte 1FF", {8'h00, v}, 16'h00C3);
    rbyte(v); check("R9 past end", {8'h00, v}, 16'h00FF);
    header("R9 R5 target overwritten", 8'hFE, 8'h01, 8'h9F);
    rbyte(v); check("R9 scratchpad page load", {8'h00, v}, 16'h005A);

    // R9: next page loaded after last byte of a page
    breset(); send(8'h0F); send(8'h3E); send(8'h00); send(8'hD4); send(8'hE5);
    breset(); send(8'h55); send(8'h3E); send(8'h00); send(8'h1F); waitprog();
    breset(); send(8'hF0); send(8'h1E); send(8'h00);
    rbyte(v); check("R9 byte 01E", {8'h00, v}, 16'h0033);
    rbyte(v); check("R9 byte 01F", {8'h00, v}, 16'h0044);
    header("R9 cross", 8'h1E, 8'h00, 8'h9F);
    rbyte(v); check("R9 next page byte 30", {8'h00, v}, 16'h00D4);
    rbyte(v); check("R9 next page byte 31", {8'h00, v}, 16'h00E5);

    // R8: mismatch leaves array unchanged
    breset(); send(8'h0F); send(8'h1C); send(8'h00); send(8'h99);
    breset(); send(8'h55); send(8'h1C); send(8'h00); send(8'h1D);
    rbyte(v); check("R8 mismatch ones", {8'h00, v}, 16'h00FF);
    breset(); send(8'hF0); send(8'h1C); send(8'h00);
    rbyte(v); check("R8 array unchanged", {8'h00, v}, 16'h0011);

    // R2: unknown command
    breset(); send(8'h3C);
    rbyte(v); check("R2 unknown command", {8'h00, v}, 16'h00FF);

    // R10: abort mid-command, new command accepted
    breset(); send(8'h0F); send(8'h07);
    header("R10 abort", 8'h07, 8'h00, 8'h1C);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule